// File: doc/BRIEF.md
# Qualifier-Branching Microprogram Sequencer

The block steps through a microprogram held in an external synchronous ROM. Each microinstruction is 56 bits wide. It is read as two 28-bit code words from two neighbouring ROM locations. The first word is kept in a holding register until the second word arrives. The two words are then joined and registered onto a bank of command lines that drive the rest of the system. Some of these lines are copied straight from the ROM bits. The others are a one-hot decode of a small opcode field.

A 6-bit select field sits in the low bits of the first word, and it does two jobs. It gives the upper six bits of the next ROM address. It also chooses one of 64 qualifier inputs. The controlled assemblies report their results on these qualifier lines. The chosen qualifier becomes the next address bit below the select field, so a single field both jumps and tests a condition.

The lowest address bit tells the two halves of a microinstruction apart. Together these give an 8-bit ROM address of the form {select, qualifier, half}.

Top module: `ucode_sequencer`

## Requirements
- R1: While the synchronous reset is asserted, `rom_addr` reads 0 and all command outputs read 0 from the first clock edge onward.
- R2: ROM addresses alternate one per cycle. The first fetch has bit 0 = 0, and the second fetch has bit 0 = 1 and the same bits [7:1] as the first fetch.
- R3: `cmd_direct` equals bits [55:6] of the joined word. The first fetched word forms bits [27:0] and the second forms bits [55:28].
- R4: In a first-fetch cycle that follows a completed microinstruction, `rom_addr[7:2]` equals bits [5:0] of that microinstruction's first word.
- R5: In that same cycle, `rom_addr[1]` equals the qualifier input whose index is those bits [5:0].
- R6: A change on any qualifier input during a second-fetch cycle has no effect on that cycle's `rom_addr`.
- R7: `cmd_strobe` is one-hot, with bit k set where k is bits [8:6] of the joined word. It reads all zero only after reset.
- R8: Command outputs change only at the clock edge that ends a first-fetch cycle. They then hold for two cycles, through the whole fetch of the next microinstruction.
- R9: After reset is released, the first fetch reads address 0. Commands stay 0 until a full microinstruction (addresses 0 and 1) has been read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rom_addr | output | 8 | ROM read address: {select, qualifier, half} |
| rom_data | input | 28 | ROM read data, valid one cycle after the address |
| qual | input | 64 | Qualifier result lines from the controlled assemblies |
| cmd_direct | output | 50 | Command lines taken directly from the joined word |
| cmd_strobe | output | 8 | One-hot decoded command strobes |

## Verification
The hardest case to reach is a qualifier that changes while the second half of a microinstruction is being fetched. The change must leave that fetch's address alone and only affect the branch of the following microinstruction. The bench changes several qualifier lines in every cycle during a long phase. The ROM image it uses has a self-loop that is left when qualifier 1 is set, followed by a two-way branch and a return. A reference model works out the expected address and command values for each cycle from the same qualifier values. A reset in the middle of a run then checks that execution restarts at address 0.

// File: rtl/ucseq_pkg.sv
package ucseq_pkg;

    localparam int SEL_W_DEF  = 6;
    localparam int WORD_W_DEF = 28;
    localparam int OP_W_DEF   = 3;

    typedef enum logic {
        PH_LO = 1'b0,
        PH_HI = 1'b1
    } phase_e;

    function automatic logic half_bit(phase_e p);
        return (p == PH_HI);
    endfunction

endpackage

// File: rtl/ucseq_qual_mux.sv
module ucseq_qual_mux #(
    parameter int SEL_W = ucseq_pkg::SEL_W_DEF
) (
    input  logic [SEL_W-1:0]      sel,
    input  logic [(1<<SEL_W)-1:0] qual,
    output logic                  q_bit
);
    localparam int NQ = 1 << SEL_W;

    logic [NQ-1:0] hit;

    for (genvar i = 0; i < NQ; i++) begin : g_tap
        assign hit[i] = qual[i] & (sel == SEL_W'(i));
    end

    assign q_bit = |hit;
endmodule

// File: rtl/ucseq_fetch.sv
module ucseq_fetch
    import ucseq_pkg::*;
#(
    parameter int SEL_W  = SEL_W_DEF,
    parameter int WORD_W = WORD_W_DEF,
    localparam int ADDR_W = SEL_W + 2,
    localparam int DIR_W  = 2 * WORD_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] rom_data,
    input  logic              q_bit,
    output logic [SEL_W-1:0]  sel,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              ui_load,
    output logic [DIR_W-1:0]  ui_cmd
);
    phase_e            phase_q;
    logic              primed_q;
    logic [SEL_W:0]    base_q;
    logic [SEL_W:0]    base_nx;
    logic [WORD_W-1:0] lo_q;

    assign sel = lo_q[SEL_W-1:0];

    always_comb begin
        base_nx = '0;
        if (primed_q) base_nx = {lo_q[SEL_W-1:0], q_bit};
    end

    always_comb begin
        if (phase_q == PH_LO) rom_addr = {base_nx, half_bit(phase_q)};
        else                  rom_addr = {base_q, half_bit(phase_q)};
    end

    assign ui_load = (phase_q == PH_LO) && primed_q;
    assign ui_cmd  = {rom_data, lo_q[WORD_W-1:SEL_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q  <= PH_LO;
            primed_q <= 1'b0;
            base_q   <= '0;
            lo_q     <= '0;
        end else begin
            case (phase_q)
                PH_LO: begin
                    base_q  <= base_nx;
                    phase_q <= PH_HI;
                end
                default: begin
                    lo_q     <= rom_data;
                    primed_q <= 1'b1;
                    phase_q  <= PH_LO;
                end
            endcase
        end
    end
endmodule

// File: rtl/ucseq_cmd.sv
module ucseq_cmd #(
    parameter int DIR_W = 50,
    parameter int OP_W  = ucseq_pkg::OP_W_DEF,
    localparam int NSTB = 1 << OP_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [DIR_W-1:0] ui_cmd,
    output logic [DIR_W-1:0] cmd_direct,
    output logic [NSTB-1:0]  cmd_strobe
);
    logic [NSTB-1:0] stb_nx;

    for (genvar i = 0; i < NSTB; i++) begin : g_dec
        assign stb_nx[i] = (ui_cmd[OP_W-1:0] == OP_W'(i));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_direct <= '0;
            cmd_strobe <= '0;
        end else if (load) begin
            cmd_direct <= ui_cmd;
            cmd_strobe <= stb_nx;
        end
    end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
    import ucseq_pkg::*;
#(
    parameter int SEL_W  = SEL_W_DEF,
    parameter int WORD_W = WORD_W_DEF,
    parameter int OP_W   = OP_W_DEF,
    localparam int ADDR_W = SEL_W + 2,
    localparam int NQ     = 1 << SEL_W,
    localparam int DIR_W  = 2 * WORD_W - SEL_W,
    localparam int NSTB   = 1 << OP_W
) (
    input  logic              clk,
    input  logic              rst,
    output logic [ADDR_W-1:0] rom_addr,
    input  logic [WORD_W-1:0] rom_data,
    input  logic [NQ-1:0]     qual,
    output logic [DIR_W-1:0]  cmd_direct,
    output logic [NSTB-1:0]   cmd_strobe
);
    logic [SEL_W-1:0] sel;
    logic             q_bit;
    logic             ui_load;
    logic [DIR_W-1:0] ui_cmd;

    ucseq_qual_mux #(.SEL_W(SEL_W)) i_qmux (
        .sel   (sel),
        .qual  (qual),
        .q_bit (q_bit)
    );

    ucseq_fetch #(.SEL_W(SEL_W), .WORD_W(WORD_W)) i_fetch (
        .clk      (clk),
        .rst      (rst),
        .rom_data (rom_data),
        .q_bit    (q_bit),
        .sel      (sel),
        .rom_addr (rom_addr),
        .ui_load  (ui_load),
        .ui_cmd   (ui_cmd)
    );

    ucseq_cmd #(.DIR_W(DIR_W), .OP_W(OP_W)) i_cmd (
        .clk        (clk),
        .rst        (rst),
        .load       (ui_load),
        .ui_cmd     (ui_cmd),
        .cmd_direct (cmd_direct),
        .cmd_strobe (cmd_strobe)
    );
endmodule

// File: rtl/ucseq_chk.sv
module ucseq_chk #(
    parameter int SEL_W  = 6,
    parameter int WORD_W = 28,
    parameter int OP_W   = 3,
    localparam int ADDR_W = SEL_W + 2,
    localparam int DIR_W  = 2 * WORD_W - SEL_W,
    localparam int NSTB   = 1 << OP_W
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] rom_addr,
    input logic [DIR_W-1:0]  cmd_direct,
    input logic [NSTB-1:0]   cmd_strobe
);
    // R1
    reset_addr_chk: assert property (@(posedge clk)
        rst |=> (rom_addr == '0 && cmd_direct == '0 && cmd_strobe == '0));

    // R2
    half_toggle_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (rom_addr[0] != $past(rom_addr[0])));

    // R2
    hi_base_chk: assert property (@(posedge clk) disable iff (rst)
        rom_addr[0] |-> (rom_addr[ADDR_W-1:1] == $past(rom_addr[ADDR_W-1:1])));

    // R8
    cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rom_addr[0] && !$past(rst)) |-> ($stable(cmd_direct) && $stable(cmd_strobe)));

    // R7
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cmd_strobe));
endmodule

bind ucode_sequencer ucseq_chk #(
    .SEL_W  (SEL_W),
    .WORD_W (WORD_W),
    .OP_W   (OP_W)
) i_ucseq_chk (
    .clk        (clk),
    .rst        (rst),
    .rom_addr   (rom_addr),
    .cmd_direct (cmd_direct),
    .cmd_strobe (cmd_strobe)
);

// File: tb/test_ucode_sequencer.sv
module test_ucode_sequencer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rom_addr;
    logic [27:0] rom_data;
    logic [63:0] qual = '0;
    logic [49:0] cmd_direct;
    logic [7:0]  cmd_strobe;

    int unsigned n_run  = 0;
    int unsigned n_fail = 0;
    bit          done   = 1'b0;

    always #10 clk = ~clk;

    ucode_sequencer i_ucode_sequencer (
        .clk        (clk),
        .rst        (rst),
        .rom_addr   (rom_addr),
        .rom_data   (rom_data),
        .qual       (qual),
        .cmd_direct (cmd_direct),
        .cmd_strobe (cmd_strobe)
    );

    // ROM image: branch graph over the low bases, pattern bits elsewhere
    logic [27:0] mem [256];

    function automatic logic [5:0] sel_of(int base);
        case (base)
            0, 1, 2: return 6'd1;
            3:       return 6'd2;
            5:       return 6'd3;
            default: return 6'd0;
        endcase
    endfunction

    initial begin
        for (int a = 0; a < 256; a++) begin
            logic [31:0] pat;
            pat = (32'(a) * 32'h9E3779B1) ^ 32'h5A5A5A5A;
            if (a % 2 == 0) mem[a] = {pat[27:6], sel_of(a / 2)};
            else            mem[a] = pat[27:0];
        end
    end

    always @(posedge clk) rom_data <= mem[rom_addr];

    // Scoreboard
    typedef struct {
        logic [7:0]  addr;
        logic [49:0] dir;
        logic [7:0]  stb;
        string       tag_a;
        string       tag_c;
    } exp_t;

    exp_t exp_q[$];

    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_run++;
            if (rom_addr !== e.addr) begin
                n_fail++;
                $display("FAIL %s rom_addr actual=%0h expected=%0h", e.tag_a, rom_addr, e.addr);
            end
            n_run++;
            if (cmd_direct !== e.dir || cmd_strobe !== e.stb) begin
                n_fail++;
                $display("FAIL %s cmd actual=%0h/%0h expected=%0h/%0h",
                         e.tag_c, cmd_direct, cmd_strobe, e.dir, e.stb);
            end
        end
    end

    // Reference model state
    logic        m_hi, m_primed;
    logic [6:0]  m_base;
    logic [27:0] m_lo, m_rom;
    logic [49:0] m_dir;
    logic [7:0]  m_stb;

    task automatic model_reset();
        m_hi = 0; m_primed = 0; m_base = '0; m_lo = '0; m_rom = '0;
        m_dir = '0; m_stb = '0;
    endtask

    // Driver: push expectation for the current cycle, then advance the model
    task automatic step();
        logic [6:0]  nb;
        logic [7:0]  ea;
        logic [55:0] ui;
        exp_t        e;
        nb = m_primed ? {m_lo[5:0], qual[m_lo[5:0]]} : 7'd0;
        ea = m_hi ? {m_base, 1'b1} : {nb, 1'b0};
        e.addr  = ea;
        e.dir   = m_dir;
        e.stb   = m_stb;
        e.tag_a = !m_primed ? "R9 R2" : (m_hi ? "R2 R6" : "R4 R5");
        e.tag_c = !m_primed ? "R9" : "R3 R7 R8";
        exp_q.push_back(e);
        if (!m_hi) begin
            m_base = nb;
            if (m_primed) begin
                ui    = {m_rom, m_lo};
                m_dir = ui[55:6];
                m_stb = 8'd1 << ui[8:6];
            end
            m_hi = 1;
        end else begin
            m_lo     = m_rom;
            m_primed = 1;
            m_hi     = 0;
        end
        m_rom = mem[ea];
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            step();
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        n_run++;
        if (rom_addr !== 8'd0 || cmd_direct !== '0 || cmd_strobe !== '0) begin
            n_fail++;
            $display("FAIL R1 reset state actual=%0h/%0h/%0h expected=0/0/0",
                     rom_addr, cmd_direct, cmd_strobe);
        end
        @(posedge clk); #1;
        rst = 1'b0;
        model_reset();
        step();
    endtask

    initial begin
        model_reset();
        do_reset();
        run(12);                 // self-loop while qualifier 1 is low
        @(posedge clk); #1;
        qual[1] = 1'b1;          // exit the loop
        step();
        run(11);
        @(posedge clk); #1;
        qual[2] = 1'b1;          // take the other branch arm
        step();
        run(11);
        // qualifiers changing every cycle, including second-fetch cycles (R6)
        for (int k = 0; k < 60; k++) begin
            logic [7:0] r;
            @(posedge clk); #1;
            r = 8'(k * 37 + 11);
            qual[3:0] = r[6:3];
            step();
        end
        do_reset();              // restart in the middle of a run
        qual = '0;
        run(10);
        @(posedge clk); @(negedge clk); #1;
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule